// File: doc/BRIEF.md
# Reset and Halt Sequencer

This block sits beside a simple bus master and decides when that master may use the bus. It samples two active-low control lines, a reset line and a halt line. A reset counts only when both lines have been held low together for a minimum number of clocks. When both lines are then released, the block fetches two 32-bit start-up vectors as 16-bit bus reads: first the supervisor stack pointer, then the program counter. After that it hands the bus to the master's own request/acknowledge traffic.

A halt request never cuts a bus cycle short. The cycle in progress runs to its acknowledge, and then the master stops with its address and data drivers disabled. Each release of the halt line while halted lets exactly one more bus cycle through, so software can be stepped one cycle at a time. The block can also drive the shared reset line low for a fixed number of clocks to reset other devices. While it does so, it ignores the low level that it sees on its own reset input.

Top module: `rsthalt_seq`

## Requirements
- R1: After power-on reset (`por_n` low), `state_o` is 0 (reset-wait), and `bus_req_o`, `bus_oe_o` and `reset_drv_o` are all 0. No bus cycle starts until a valid reset sequence completes.
- R2: In reset-wait, a reset is accepted only after `reset_in_n` and `halt_in_n` are sampled low together on at least `MIN_HOLD` consecutive clock edges. A shorter hold followed by a release leaves the block in state 0 with no bus request, and the partial count is discarded.
- R3: Once a reset is accepted, vector fetching does not start while either line is still low. The block stays in state 0 with `bus_req_o` low until both lines read high.
- R4: Vector fetching is state 1. It issues reads at byte addresses 0, 2, 4 and 6 in that order, starting on the cycle after release. Each address is held until `bus_ack_i` is seen.
- R5: `ssp_o` is {word at 0, word at 2} and `pc_o` is {word at 4, word at 6}. The high word is read first. After the fourth acknowledge, `state_o` becomes 2 (running).
- R6: If `halt_in_n` goes low while running, a bus cycle already in progress keeps `bus_req_o` high until its acknowledge. No new cycle starts. On the next clock the state becomes 3 (halted).
- R7: While halted, `bus_req_o` and `bus_oe_o` are 0 whatever `core_req_i` does.
- R8: Releasing `halt_in_n` while halted enters state 4 (stepping). Exactly one bus cycle runs there. After its acknowledge, the state is 3 if `halt_in_n` is low again, and 2 if it is still high.
- R9: A one-cycle pulse on `rst_out_req_i` holds `reset_drv_o` high for exactly `DRIVE_CYC` cycles, starting on the next cycle. A low `reset_in_n` during that window is ignored, and the state does not change.
- R10: A low `reset_in_n` outside the drive window, in any state other than 0, returns the block to state 0 on the next clock and drops `bus_req_o`.
- R11: While running with `halt_in_n` high, `bus_req_o` equals `core_req_i`, `bus_addr_o` equals `core_addr_i`, and `core_ack_o` equals `bus_ack_i` during a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on register reset, active low |
| reset_in_n | input | 1 | Sampled level of the shared reset line, active low |
| halt_in_n | input | 1 | Sampled level of the halt line, active low |
| rst_out_req_i | input | 1 | Pulse to start driving the shared reset line |
| reset_drv_o | output | 1 | 1 = pull the shared reset line low |
| core_req_i | input | 1 | Master requests a bus cycle |
| core_addr_i | input | ADDR_W | Master's bus address |
| core_ack_o | output | 1 | Acknowledge passed back to the master |
| bus_req_o | output | 1 | Bus cycle request |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_oe_o | output | 1 | 1 = address/data drivers on, 0 = tristated |
| bus_ack_i | input | 1 | Bus cycle acknowledge |
| bus_data_i | input | DATA_W | Read data, valid with the acknowledge |
| ssp_o | output | VEC_W | Loaded supervisor stack pointer |
| pc_o | output | VEC_W | Loaded program counter |
| state_o | output | 3 | 0 reset-wait, 1 fetch, 2 running, 3 halted, 4 stepping |

## Verification
A wrong hold count shows up as a state change to 1 either one edge early or not at all. The bench therefore tests a hold of exactly the minimum, plus shorter holds repeated back to back, which catches a count that was not discarded. A wrong word index shows on `bus_addr_o` the cycle after an acknowledge, and shows in `ssp_o`/`pc_o` as soon as state 2 appears. A faulty in-progress flag either drops `bus_req_o` in the cycle after halt goes low, or lets a second request through in state 3 or 4. The bench checks this on the very next sample.

// File: rtl/rsthalt_pkg.sv
package rsthalt_pkg;
   typedef enum logic [2:0] {
      ST_RWAIT = 3'd0,
      ST_FETCH = 3'd1,
      ST_RUN   = 3'd2,
      ST_HALT  = 3'd3,
      ST_STEP  = 3'd4
   } seq_state_e;
endpackage

// File: rtl/rsthalt_hold_filter.sv
module rsthalt_hold_filter #(
   parameter int MIN_HOLD = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic enable_i,
   input  logic both_low_i,
   output logic armed_o
);
   localparam int CW = $clog2(MIN_HOLD + 1);
   localparam logic [CW-1:0] CMAX = CW'(MIN_HOLD);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
      end else if (!enable_i) begin
         cnt_q <= '0;
      end else if (both_low_i) begin
         if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      end else if (cnt_q != CMAX) begin
         cnt_q <= '0;
      end
   end

   assign armed_o = (cnt_q == CMAX);

   // R2: the hold count never runs past its window
   a_r2_cnt_cap : assert property (@(posedge clk) disable iff (!por_n)
      cnt_q <= CMAX);
   // R2: a release before arming discards the count
   a_r2_short_clears : assert property (@(posedge clk) disable iff (!por_n)
      (enable_i && !both_low_i && !armed_o) |=> !armed_o);
endmodule

// File: rtl/rsthalt_rst_drive.sv
module rsthalt_rst_drive #(
   parameter int DRIVE_CYC = 12
) (
   input  logic clk,
   input  logic por_n,
   input  logic req_i,
   output logic drive_o
);
   generate
      if (DRIVE_CYC == 0) begin : g_none
         logic unused_req;
         assign unused_req = req_i;
         assign drive_o = 1'b0;
      end else begin : g_cnt
         localparam int DW = $clog2(DRIVE_CYC + 1);
         logic [DW-1:0] cnt_q;

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)               cnt_q <= '0;
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
            else if (req_i)           cnt_q <= DW'(DRIVE_CYC);
         end

         assign drive_o = (cnt_q != '0);

         // R9: a request while idle starts driving on the next cycle
         a_r9_start : assert property (@(posedge clk) disable iff (!por_n)
            (req_i && !drive_o) |=> drive_o);
      end
   endgenerate
endmodule

// File: rtl/rsthalt_vec_cap.sv
module rsthalt_vec_cap #(
   parameter int DATA_W = 16,
   parameter int WPV    = 2,
   parameter int NVEC   = 2,
   localparam int NW    = WPV * NVEC,
   localparam int IW    = $clog2(NW),
   localparam int VEC_W = WPV * DATA_W
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   wr_i,
   input  logic [IW-1:0]          widx_i,
   input  logic [DATA_W-1:0]      data_i,
   output logic [NVEC*VEC_W-1:0]  vec_o
);
   generate
      for (genvar k = 0; k < NW; k++) begin : g_word
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                          q <= '0;
            else if (wr_i && widx_i == IW'(k))   q <= data_i;
         end
         // earlier word of a vector lands in its upper half
         assign vec_o[(k / WPV) * VEC_W + (WPV - 1 - (k % WPV)) * DATA_W +: DATA_W] = q;
      end
   endgenerate

   // R5: vectors change only on a captured fetch word
   a_r5_hold : assert property (@(posedge clk) disable iff (!por_n)
      !wr_i |=> $stable(vec_o));
endmodule

// File: rtl/rsthalt_seq.sv
module rsthalt_seq
   import rsthalt_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 16,
   parameter int VEC_W     = 32,
   parameter int MIN_HOLD  = 8,
   parameter int DRIVE_CYC = 12
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              reset_in_n,
   input  logic              halt_in_n,
   input  logic              rst_out_req_i,
   output logic              reset_drv_o,
   input  logic              core_req_i,
   input  logic [ADDR_W-1:0] core_addr_i,
   output logic              core_ack_o,
   output logic              bus_req_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_oe_o,
   input  logic              bus_ack_i,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic [VEC_W-1:0]  ssp_o,
   output logic [VEC_W-1:0]  pc_o,
   output logic [2:0]        state_o
);
   localparam int WPV  = VEC_W / DATA_W;
   localparam int NW   = 2 * WPV;
   localparam int WIX  = $clog2(NW);
   localparam int BSH  = $clog2(DATA_W / 8);

   generate
      if (DATA_W % 8 != 0 || VEC_W % DATA_W != 0 || WPV < 1) begin : g_bad_width
         $error("rsthalt_seq: DATA_W must be whole bytes and divide VEC_W");
      end
      if (MIN_HOLD < 1) begin : g_bad_hold
         $error("rsthalt_seq: MIN_HOLD must be at least 1");
      end
      if (ADDR_W < WIX + BSH) begin : g_bad_addr
         $error("rsthalt_seq: ADDR_W too narrow for vector addresses");
      end
   endgenerate

   seq_state_e       st_q, st_d;
   logic [WIX-1:0]   widx_q;
   logic             cyc_q;
   logic             armed;
   logic             rst_low;
   logic [2*VEC_W-1:0] vec_flat;

   rsthalt_rst_drive #(.DRIVE_CYC(DRIVE_CYC)) u_drive (
      .clk     (clk),
      .por_n   (por_n),
      .req_i   (rst_out_req_i),
      .drive_o (reset_drv_o)
   );

   // own outward drive is echoed on the input; do not treat it as a reset
   assign rst_low = !reset_in_n && !reset_drv_o;

   rsthalt_hold_filter #(.MIN_HOLD(MIN_HOLD)) u_filter (
      .clk        (clk),
      .por_n      (por_n),
      .enable_i   (st_q == ST_RWAIT),
      .both_low_i (rst_low && !halt_in_n),
      .armed_o    (armed)
   );

   always_comb begin
      unique case (st_q)
         ST_FETCH: bus_req_o = 1'b1;
         ST_RUN:   bus_req_o = core_req_i && (halt_in_n || cyc_q);
         ST_STEP:  bus_req_o = core_req_i;
         default:  bus_req_o = 1'b0;
      endcase
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RWAIT: if (armed && !rst_low && halt_in_n) st_d = ST_FETCH;
         ST_FETCH: if (bus_ack_i && widx_q == WIX'(NW - 1)) st_d = ST_RUN;
         ST_RUN:   if (!halt_in_n && (!cyc_q || bus_ack_i)) st_d = ST_HALT;
         ST_HALT:  if (halt_in_n) st_d = ST_STEP;
         ST_STEP:  if (bus_req_o && bus_ack_i) st_d = halt_in_n ? ST_RUN : ST_HALT;
         default:  st_d = ST_RWAIT;
      endcase
      if (rst_low && st_q != ST_RWAIT) st_d = ST_RWAIT;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q   <= ST_RWAIT;
         widx_q <= '0;
         cyc_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         if (st_q != ST_FETCH)  widx_q <= '0;
         else if (bus_ack_i)    widx_q <= widx_q + 1'b1;
         cyc_q  <= (st_q == ST_RUN) && (st_d == ST_RUN) && bus_req_o && !bus_ack_i;
      end
   end

   rsthalt_vec_cap #(.DATA_W(DATA_W), .WPV(WPV), .NVEC(2)) u_vec (
      .clk    (clk),
      .por_n  (por_n),
      .wr_i   (st_q == ST_FETCH && bus_ack_i),
      .widx_i (widx_q),
      .data_i (bus_data_i),
      .vec_o  (vec_flat)
   );

   assign ssp_o      = vec_flat[0 +: VEC_W];
   assign pc_o       = vec_flat[VEC_W +: VEC_W];
   assign bus_oe_o   = (st_q == ST_FETCH) || (st_q == ST_RUN) || (st_q == ST_STEP);
   assign bus_addr_o = (st_q == ST_FETCH) ? (ADDR_W'(widx_q) << BSH)
                     : (bus_oe_o ? core_addr_i : '0);
   assign core_ack_o = bus_ack_i && bus_req_o && (st_q == ST_RUN || st_q == ST_STEP);
   assign state_o    = st_q;

   // R2: fetching begins only from an armed hold window
   a_r2_fetch_needs_arm : assert property (@(posedge clk) disable iff (!por_n)
      (st_q == ST_FETCH && $past(st_q) == ST_RWAIT) |-> $past(armed));
   // R4: a fetch address is held until acknowledged
   a_r4_fetch_addr_hold : assert property (@(posedge clk) disable iff (!por_n)
      (st_q == ST_FETCH && !bus_ack_i && !rst_low) |=> $stable(bus_addr_o));
   // R6: a started cycle is never withdrawn before its acknowledge
   a_r6_cycle_kept : assert property (@(posedge clk) disable iff (!por_n)
      (st_q == ST_RUN && cyc_q) |-> bus_req_o);
   // R7: halted master leaves the bus floating and idle
   a_r7_halt_quiet : assert property (@(posedge clk) disable iff (!por_n)
      (st_q == ST_HALT) |-> (!bus_req_o && !bus_oe_o));
   // R8: stepping ends with its one acknowledged cycle
   a_r8_step_single : assert property (@(posedge clk) disable iff (!por_n)
      (st_q == ST_STEP && bus_req_o && bus_ack_i && !rst_low) |=> st_q != ST_STEP);
   // R10: an external reset aborts any activity
   a_r10_reset_wins : assert property (@(posedge clk) disable iff (!por_n)
      (rst_low && st_q != ST_RWAIT) |=> st_q == ST_RWAIT);
endmodule

// File: tb/rsthalt_seq_tb.sv
`timescale 1ns/1ps
module rsthalt_seq_tb_top;
   localparam int AW  = 24;
   localparam int DW  = 16;
   localparam int VW  = 32;
   localparam int MIN = 8;
   localparam int DRV = 12;

   logic clk = 1'b0;
   logic por_n, reset_in_n, halt_in_n, rst_out_req_i, reset_drv_o;
   logic core_req_i, core_ack_o, bus_req_o, bus_oe_o, bus_ack_i;
   logic [AW-1:0] core_addr_i, bus_addr_o;
   logic [DW-1:0] bus_data_i;
   logic [VW-1:0] ssp_o, pc_o;
   logic [2:0]    state_o;

   int checks = 0;
   int errs   = 0;
   logic [15:0] salt_g = 16'h5a3c;
   bit resp_auto = 1'b1;
   bit core_auto = 1'b0;
   bit cak_q = 1'b0;
   int wait_n = 0;
   logic [AW-1:0] log_a [8];
   int log_n = 0;

   always #2 clk = ~clk;

   rsthalt_seq #(.ADDR_W(AW), .DATA_W(DW), .VEC_W(VW), .MIN_HOLD(MIN), .DRIVE_CYC(DRV)) dut_i (
      .clk(clk), .por_n(por_n), .reset_in_n(reset_in_n), .halt_in_n(halt_in_n),
      .rst_out_req_i(rst_out_req_i), .reset_drv_o(reset_drv_o),
      .core_req_i(core_req_i), .core_addr_i(core_addr_i), .core_ack_o(core_ack_o),
      .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_oe_o(bus_oe_o),
      .bus_ack_i(bus_ack_i), .bus_data_i(bus_data_i),
      .ssp_o(ssp_o), .pc_o(pc_o), .state_o(state_o)
   );

   function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
      logic [15:0] t;
      t = a[15:0] * 16'd40503;
      return t ^ salt_g;
   endfunction

   // bus memory responder and master model
   always @(negedge clk) begin
      if (cak_q) core_req_i = 1'b0;
      if (resp_auto) begin
         if (bus_ack_i) bus_ack_i = 1'b0;
         else if (bus_req_o) begin
            if (wait_n == 0) begin
               bus_ack_i  = 1'b1;
               bus_data_i = mem_word(bus_addr_o);
               if (state_o == 3'd1 && log_n < 8) begin
                  log_a[log_n] = bus_addr_o;
                  log_n++;
               end
               wait_n = $urandom % 3;
            end else wait_n--;
         end
      end
      if (core_auto && !core_req_i && !cak_q && ($urandom % 3 == 0)) begin
         core_req_i  = 1'b1;
         core_addr_i = AW'($urandom);
      end
      #1.5;
      cak_q = core_ack_o;
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic wait_st(input logic [2:0] s, input int lim, input string r);
      int n = 0;
      while (state_o != s && n < lim) begin
         tick();
         n++;
      end
      chk(r, state_o, s);
   endtask

   task automatic man_ack();
      bus_ack_i  = 1'b1;
      bus_data_i = mem_word(bus_addr_o);
      tick();
      bus_ack_i  = 1'b0;
   endtask

   task automatic do_reset(input int hold, input logic [15:0] salt);
      salt_g = salt;
      log_n = 0;
      reset_in_n = 1'b0;
      halt_in_n  = 1'b0;
      repeat (hold) tick();
      reset_in_n = 1'b1;
      tick(); tick();
      chk("R3 wait state", state_o, 3'd0);
      chk("R3 no req", bus_req_o, 1'b0);
      halt_in_n = 1'b1;
      tick();
      chk("R4 fetch state", state_o, 3'd1);
      chk("R4 first addr", bus_addr_o, 0);
      wait_st(3'd2, 40, "R5 running");
      chk("R4 fetch count", log_n, 4);
      for (int k = 0; k < 4; k++) chk("R4 fetch order", log_a[k], 2 * k);
      chk("R5 ssp", ssp_o, {mem_word(0), mem_word(2)});
      chk("R5 pc", pc_o, {mem_word(4), mem_word(6)});
   endtask

   task automatic run_rand(input int n);
      resp_auto = 1'b1;
      core_auto = 1'b1;
      for (int i = 0; i < n; i++) begin
         tick();
         if (state_o == 3'd2) begin
            chk("R11 req", bus_req_o, core_req_i);
            if (core_req_i) chk("R11 addr", bus_addr_o, core_addr_i);
            chk("R11 ack", core_ack_o, bus_ack_i && core_req_i);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      por_n = 1'b0; reset_in_n = 1'b1; halt_in_n = 1'b1; rst_out_req_i = 1'b0;
      core_req_i = 1'b0; core_addr_i = '0; bus_ack_i = 1'b0; bus_data_i = '0;
      repeat (3) tick();
      por_n = 1'b1;
      repeat (4) tick();
      chk("R1 state", state_o, 3'd0);
      chk("R1 req", bus_req_o, 1'b0);
      chk("R1 oe", bus_oe_o, 1'b0);
      chk("R1 drv", reset_drv_o, 1'b0);

      // R2: short holds, back to back, including one edge short
      for (int t = 0; t < 4; t++) begin
         int len;
         len = (t == 0) ? MIN - 1 : 1 + ($urandom % (MIN - 1));
         reset_in_n = 1'b0; halt_in_n = 1'b0;
         repeat (len) tick();
         reset_in_n = 1'b1; halt_in_n = 1'b1;
         repeat (3) tick();
         chk("R2 short hold state", state_o, 3'd0);
         chk("R2 short hold req", bus_req_o, 1'b0);
      end

      do_reset(MIN, 16'h1234);
      run_rand(200);

      // R6/R7: halt with a cycle in flight
      core_auto = 1'b0;
      for (int i = 0; i < 30 && (core_req_i || bus_ack_i); i++) tick();
      resp_auto = 1'b0;
      core_req_i = 1'b1; core_addr_i = 24'h00abce;
      tick();
      chk("R11 req directed", bus_req_o, 1'b1);
      halt_in_n = 1'b0;
      tick();
      chk("R6 still running", state_o, 3'd2);
      chk("R6 req kept", bus_req_o, 1'b1);
      chk("R6 addr kept", bus_addr_o, 24'h00abce);
      man_ack();
      chk("R6 halted", state_o, 3'd3);
      chk("R6 oe off", bus_oe_o, 1'b0);
      core_req_i = 1'b1;
      repeat (3) tick();
      chk("R7 no req", bus_req_o, 1'b0);
      chk("R7 oe off", bus_oe_o, 1'b0);

      // R8: one step then halted again
      halt_in_n = 1'b1;
      tick();
      chk("R8 stepping", state_o, 3'd4);
      chk("R8 step req", bus_req_o, 1'b1);
      halt_in_n = 1'b0;
      tick();
      chk("R8 step pending", bus_req_o, 1'b1);
      man_ack();
      chk("R8 back halted", state_o, 3'd3);
      core_req_i = 1'b1;
      tick();
      chk("R8 only one cycle", bus_req_o, 1'b0);
      halt_in_n = 1'b1;
      tick();
      chk("R8 step again", state_o, 3'd4);
      man_ack();
      chk("R8 resumes running", state_o, 3'd2);
      run_rand(100);

      // R9: outward reset drive with echoed input
      rst_out_req_i = 1'b1;
      tick();
      rst_out_req_i = 1'b0;
      begin
         int cnt = 0;
         while (reset_drv_o && cnt < 50) begin
            cnt++;
            reset_in_n = (cnt > 8);
            tick();
         end
         reset_in_n = 1'b1;
         chk("R9 drive length", cnt, DRV);
      end
      chk("R9 echo ignored", state_o, 3'd2);
      run_rand(50);

      // R10: reset alone aborts running
      reset_in_n = 1'b0;
      tick();
      chk("R10 state", state_o, 3'd0);
      chk("R10 req", bus_req_o, 1'b0);
      reset_in_n = 1'b1;
      tick();

      // random reset trials from running
      for (int t = 0; t < 3; t++) begin
         do_reset(MIN + 1 + ($urandom % 4), 16'($urandom));
         run_rand(150);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule